// File: doc/BRIEF.md
# Packed Byte Set-Less-Than Execution Unit

This unit decodes one 32-bit instruction word for a SIMD coprocessor and carries out a lane-wise "set less than" over packed bytes. It has sixteen register names. Name 0 is a constant zero. Names 1 to 15 are writable 32-bit storage entries that are cleared at reset. The instruction names two sources, B and C, and a destination. Each of the four byte lanes of B is compared with the same lane of C. A lane whose B byte is smaller produces the byte value 0x01, and any other lane produces 0x00. The four result bytes are packed and written to the destination.

A separate 6-bit sub-opcode picks the byte interpretation: two's complement or plain 0 to 255. A sub-opcode that names neither mode raises a reserved-instruction pulse and changes no register. The unit also refuses malformed words, in which the padding bits are not zero, and it discards any write aimed at register zero. A debug port can read any register combinationally and can preload storage entries. Preloading is the only way operands other than 0x00 and 0x01 bytes can enter the register file.

Top module: `pbslt_unit`

## Requirements
- R1: Instruction bits 17:14 name source C, bits 13:10 name source B and bits 9:6 name the destination. The packed result is written on the rising edge that samples `instValid` high, and it can be read on the debug port right after that edge.
- R2: Result byte i (bits 8i+7:8i, i = 0..3) is 0x01 when byte i of B is less than byte i of C, and 0x00 otherwise. No other result bit is ever set.
- R3: Sub-opcode 0x06 compares each byte as a two's-complement value from -128 to 127.
- R4: Sub-opcode 0x07 compares each byte as an unsigned value from 0 to 255.
- R5: When instruction bits 25:21 are not all zero, the instruction leaves every register unchanged.
- R6: A destination index of 0 causes no register write.
- R7: Register index 0 reads as zero, both as a source operand and on the debug port.
- R8: When both source indices are equal, including the case where both are 0, the result written is all zeros.
- R9: Any other sub-opcode writes no register. It raises `rsvdFlag` for exactly the one cycle after the edge that samples the instruction, and `rsvdFlag` is low at all other times.
- R10: Reset clears all fifteen storage entries to zero.
- R11: `dbgData` shows the register named by `dbgIdx` combinationally. When `dbgWrEn` is high, `dbgWrData` is written to that register on the clock edge, unless the index is 0. An instruction write to the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | Instruction word and sub-opcode are valid this cycle |
| instWord | input | 32 | Instruction word |
| subOp | input | 6 | Sub-opcode selecting the compare mode |
| dbgIdx | input | 4 | Debug register index for read and preload |
| dbgWrEn | input | 1 | Debug preload strobe |
| dbgWrData | input | 32 | Debug preload value |
| dbgData | output | 32 | Value of the register named by dbgIdx |
| rsvdFlag | output | 1 | One-cycle reserved sub-opcode pulse |

## Verification
A wrong lane comparison or a wrong field decode leaves a bad byte in the destination. That byte shows on the debug port as early as the first negative clock edge after the instruction's sampling edge. A wrong signedness choice only shows when some lane holds a byte at or above 0x80. For that reason the sweep mixes the values 0x7F, 0x80, 0x81 and 0xFF across lanes in both modes. A suppression fault caused by padding, destination zero or a reserved sub-opcode shows as a change in a preloaded register, or as a wrong `rsvdFlag` level, within one cycle.

// File: rtl/pbslt_pkg.sv
package pbslt_pkg;
  localparam int IDX_W = 4;

  localparam logic [5:0] OP_SLT_S = 6'h06;
  localparam logic [5:0] OP_SLT_U = 6'h07;

  typedef struct packed {
    logic              wrEn;
    logic              signedMode;
    logic              forceZero;
    logic              rsvd;
    logic [IDX_W-1:0]  dstIdx;
    logic [IDX_W-1:0]  srcBIdx;
    logic [IDX_W-1:0]  srcCIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/pbslt_lane_cmp.sv
module pbslt_lane_cmp #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] laneB,
  input  logic [LANE_W-1:0] laneC,
  input  logic              signedMode,
  output logic              isLess
);
  logic [LANE_W:0] extB;
  logic [LANE_W:0] extC;

  // Widen by one bit: sign bit copied in signed mode, zero in unsigned mode,
  // then compare the widened values as signed numbers.
  always_comb begin
    extB = {signedMode & laneB[LANE_W-1], laneB};
    extC = {signedMode & laneC[LANE_W-1], laneC};
    isLess = $signed(extB) < $signed(extC);
  end
endmodule

// File: rtl/pbslt_ctrl.sv
module pbslt_ctrl
  import pbslt_pkg::*;
#(
  parameter int INST_W = 32,
  parameter int PAD_HI = 25,
  parameter int PAD_LO = 21,
  parameter int SRCC_LO = 14,
  parameter int SRCB_LO = 10,
  parameter int DST_LO = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [5:0]        subOp,
  output ctrlStrobes_t      strb,
  output logic              rsvdFlag
);
  localparam int PAD_W = PAD_HI - PAD_LO + 1;

  logic [PAD_W-1:0] padField;
  logic             knownOp;
  logic             padOk;

  always_comb begin
    padField     = instWord[PAD_HI:PAD_LO];
    padOk        = (padField == '0);
    knownOp      = (subOp == OP_SLT_S) || (subOp == OP_SLT_U);
    strb.srcCIdx = instWord[SRCC_LO +: IDX_W];
    strb.srcBIdx = instWord[SRCB_LO +: IDX_W];
    strb.dstIdx  = instWord[DST_LO +: IDX_W];
    strb.signedMode = (subOp == OP_SLT_S);
    strb.forceZero  = (strb.srcBIdx == strb.srcCIdx);
    strb.rsvd       = instValid && !knownOp;
    strb.wrEn       = instValid && knownOp && padOk && (strb.dstIdx != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rsvdFlag <= 1'b0;
    else       rsvdFlag <= strb.rsvd;
  end
endmodule

// File: rtl/pbslt_datapath.sv
module pbslt_datapath
  import pbslt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int NREGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [IDX_W-1:0]  dbgIdx,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgData,
  output logic [DATA_W-1:0] wrData
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int NSTORE = NREGS - 1;

  logic [DATA_W-1:0] store [NSTORE];
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] opC;
  logic [LANES-1:0]  laneLess;
  logic [DATA_W-1:0] packed_res;

  function automatic logic [DATA_W-1:0] readReg(input logic [IDX_W-1:0] idx,
                                                input logic [DATA_W-1:0] s [NSTORE]);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int n = 1; n < NREGS; n++)
      if (idx == IDX_W'(n)) v = s[n-1];
    return v;
  endfunction

  always_comb begin
    opB     = readReg(strb.srcBIdx, store);
    opC     = readReg(strb.srcCIdx, store);
    dbgData = readReg(dbgIdx, store);
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    pbslt_lane_cmp #(.LANE_W(LANE_W)) uCmp (
      .laneB     (opB[g*LANE_W +: LANE_W]),
      .laneC     (opC[g*LANE_W +: LANE_W]),
      .signedMode(strb.signedMode),
      .isLess    (laneLess[g])
    );
    assign packed_res[g*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, laneLess[g]};
  end

  assign wrData = strb.forceZero ? '0 : packed_res;

  for (genvar n = 1; n < NREGS; n++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        store[n-1] <= '0;
      else if (strb.wrEn && strb.dstIdx == IDX_W'(n))
        store[n-1] <= wrData;
      else if (dbgWrEn && dbgIdx == IDX_W'(n))
        store[n-1] <= dbgWrData;
    end
  end
endmodule

// File: rtl/pbslt_unit.sv
module pbslt_unit
  import pbslt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int NREGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [5:0]        subOp,
  input  logic [3:0]        dbgIdx,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgData,
  output logic              rsvdFlag
);
  ctrlStrobes_t      strb;
  logic [DATA_W-1:0] wrData;

  pbslt_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instWord (instWord),
    .subOp    (subOp),
    .strb     (strb),
    .rsvdFlag (rsvdFlag)
  );

  pbslt_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .NREGS(NREGS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dbgIdx   (dbgIdx),
    .dbgWrEn  (dbgWrEn),
    .dbgWrData(dbgWrData),
    .dbgData  (dbgData),
    .wrData   (wrData)
  );
endmodule

// File: rtl/pbslt_chk.sv
module pbslt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic [5:0]  subOp,
  input logic [3:0]  dbgIdx,
  input logic [31:0] dbgData,
  input logic        rsvdFlag,
  input logic        wrEn,
  input logic [31:0] wrData
);
  // R5
  pad_suppress_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[25:21] != 5'd0) |-> !wrEn);

  // R6
  dst_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[9:6] == 4'd0) |-> !wrEn);

  // R7
  zero_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgIdx == 4'd0) |-> (dbgData == 32'd0));

  // R2
  lane_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((wrData & 32'hFEFE_FEFE) == 32'd0));

  // R8
  same_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && instWord[17:14] == instWord[13:10]) |-> (wrData == 32'd0));

  // R9
  rsvd_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && subOp != 6'h06 && subOp != 6'h07) |=> rsvdFlag);

  // R9
  rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!instValid || subOp == 6'h06 || subOp == 6'h07) |=> !rsvdFlag);

  // R9
  rsvd_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && subOp != 6'h06 && subOp != 6'h07) |-> !wrEn);
endmodule

bind pbslt_unit pbslt_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .instValid(instValid),
  .instWord (instWord),
  .subOp    (subOp),
  .dbgIdx   (dbgIdx),
  .dbgData  (dbgData),
  .rsvdFlag (rsvdFlag),
  .wrEn     (strb.wrEn),
  .wrData   (wrData)
);

// File: tb/tb_pbslt_unit.sv
module tb_pbslt_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [5:0]  subOp = '0;
  logic [3:0]  dbgIdx = '0;
  logic        dbgWrEn = 1'b0;
  logic [31:0] dbgWrData = '0;
  logic [31:0] dbgData;
  logic        rsvdFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] model [16];

  pbslt_unit dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .subOp(subOp), .dbgIdx(dbgIdx), .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData),
    .dbgData(dbgData), .rsvdFlag(rsvdFlag)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] refSlt(input logic [31:0] b, input logic [31:0] c,
                                         input bit sgn);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      int vb, vc;
      vb = int'(b[8*i +: 8]);
      vc = int'(c[8*i +: 8]);
      if (sgn && vb > 127) vb = vb - 256;
      if (sgn && vc > 127) vc = vc - 256;
      r[8*i] = (vb < vc);
    end
    return r;
  endfunction

  function automatic logic [7:0] pick(input int k);
    case (k % 8)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;  3: return 8'h80;
      4: return 8'h81;  5: return 8'hFF;  6: return 8'h3C;  default: return 8'hC3;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input int idx, input logic [31:0] val);
    @(negedge clk);
    dbgIdx = 4'(idx); dbgWrEn = 1'b1; dbgWrData = val;
    @(negedge clk);
    dbgWrEn = 1'b0;
    if (idx != 0) model[idx] = val;
  endtask

  task automatic readReg(input int idx, output logic [31:0] v);
    dbgIdx = 4'(idx);
    #1 v = dbgData;
  endtask

  // Drives one instruction; returns at the negedge after its sampling edge.
  task automatic issue(input logic [5:0] op, input logic [4:0] pad,
                       input int c, input int b, input int a);
    @(negedge clk);
    instValid = 1'b1; subOp = op;
    instWord = {6'd0, pad, 3'd0, 4'(c), 4'(b), 4'(a), 6'd0};
    @(negedge clk);
    instValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset clears storage, R7 index 0 reads zero
    for (int i = 0; i < 16; i++) begin
      readReg(i, v);
      check(i == 0 ? "R7" : "R10", v, 32'd0);
    end
    check("R9 idle", {31'd0, rsvdFlag}, 32'd0);

    // R1 R2 R3 R4 sweep over mixed boundary bytes, both modes
    for (int x = 0; x < 256; x++) begin
      for (int m = 0; m < 2; m++) begin
        logic [31:0] bv, cv, exp;
        int bi, ci, di;
        for (int k = 0; k < 4; k++) begin
          bv[8*k +: 8] = pick(x + 3*k);
          cv[8*k +: 8] = pick(x/8 + 5*k + m);
        end
        bi = 1 + (x % 4); ci = 5 + (x % 4); di = 9 + (x % 7);
        preload(bi, bv);
        preload(ci, cv);
        exp = refSlt(bv, cv, m == 0);
        issue(m == 0 ? 6'h06 : 6'h07, 5'd0, ci, bi, di);
        model[di] = exp;
        readReg(di, v);
        check(m == 0 ? "R3 R1 R2" : "R4 R1 R2", v, exp);
      end
    end

    // R3 and R4 on a fixed boundary pattern
    preload(1, 32'h80FF7F00);
    preload(2, 32'h7F0080FF);
    issue(6'h06, 5'd0, 2, 1, 3);
    readReg(3, v); check("R3 fixed", v, 32'h01010000);
    issue(6'h07, 5'd0, 2, 1, 3);
    readReg(3, v); check("R4 fixed", v, 32'h00000101);

    // R5 nonzero padding leaves registers alone
    preload(4, 32'hDEADBEEF);
    for (int p = 1; p < 32; p = p * 2 + 1) begin
      issue(6'h07, 5'(p), 2, 1, 4);
      readReg(4, v); check("R5", v, 32'hDEADBEEF);
    end

    // R6 destination zero
    issue(6'h07, 5'd0, 2, 1, 0);
    readReg(0, v); check("R6", v, 32'd0);
    readReg(1, v); check("R6 src kept", v, 32'h80FF7F00);
    readReg(2, v); check("R6 src kept", v, 32'h7F0080FF);

    // R7 register zero as a source
    preload(5, 32'h01FF8001);
    issue(6'h07, 5'd0, 5, 0, 6);
    readReg(6, v); check("R7 src0 unsigned", v, 32'h01010101);
    issue(6'h06, 5'd0, 5, 0, 6);
    readReg(6, v); check("R7 src0 signed", v, 32'h01000001);
    issue(6'h06, 5'd0, 0, 5, 6);
    readReg(6, v); check("R7 srcC0 signed", v, refSlt(32'h01FF8001, 32'd0, 1'b1));

    // R8 equal sources
    preload(7, 32'h12345678);
    issue(6'h06, 5'd0, 1, 1, 7);
    readReg(7, v); check("R8 same", v, 32'd0);
    preload(7, 32'h12345678);
    issue(6'h07, 5'd0, 0, 0, 7);
    readReg(7, v); check("R8 both zero", v, 32'd0);

    // R9 reserved sub-opcodes: one-cycle flag, no write
    for (int op = 0; op < 64; op += 9) begin
      if (op == 6 || op == 7) continue;
      preload(8, 32'hA5A5A5A5);
      issue(6'(op), 5'd0, 2, 1, 8);
      check("R9 flag high", {31'd0, rsvdFlag}, 32'd1);
      readReg(8, v); check("R9 no write", v, 32'hA5A5A5A5);
      @(negedge clk);
      check("R9 flag one cycle", {31'd0, rsvdFlag}, 32'd0);
    end
    issue(6'h06, 5'd0, 2, 1, 8);
    check("R9 flag low on valid op", {31'd0, rsvdFlag}, 32'd0);

    // R11 preload ignored at index 0; instruction wins same-cycle collision
    preload(0, 32'hFFFFFFFF);
    readReg(0, v); check("R11 idx0", v, 32'd0);
    @(negedge clk);
    instValid = 1'b1; subOp = 6'h07;
    instWord = {6'd0, 5'd0, 3'd0, 4'd2, 4'd1, 4'd9, 6'd0};
    dbgIdx = 4'd9; dbgWrEn = 1'b1; dbgWrData = 32'hCAFEF00D;
    @(negedge clk);
    instValid = 1'b0; dbgWrEn = 1'b0;
    readReg(9, v); check("R11 priority", v, refSlt(32'h80FF7F00, 32'h7F0080FF, 1'b0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule